// File: doc/BRIEF.md
# SDRAM Single-Bank Command Legality Tracker

This block watches the command strobes of an SDRAM device and follows the state of one bank. The strobes are chip select, row strobe, column strobe and write enable. Each cycle it decodes the strobes into a command and advances a per-bank state machine. It flags any command that the bank's current state does not allow. A memory controller or a verification environment places one instance per bank. The bank-match qualifier is driven high when the bank address of the command selects this bank.

The tracker models the timed transient phases that must not be interrupted. These are opening a row (tRCD), closing a row (tRP), and bursts that close the row automatically. It also models bursts that can be restarted, truncated by a close, or ended early by a burst stop. A flagged command does not change the bank's state, and the timers keep running as if the command were a no-operation. The clock enable is assumed to be high at all times. Arbitration between banks, refresh scheduling, the data path and the low-power modes are not part of this block.

The parameters `T_RCD` and `T_RP` must each be at least 2. `burstLen` holds the programmed burst length in cycles.

Top module: `sdram_bank_tracker`

## Requirements
- R1: `cmdCode` decodes the current strobes combinationally. With `csN` high it is 0 (inhibit). With `csN` low, {rasN,casN,weN} maps as follows: 111 to 1 (no-op), 011 to 2 (open row), 101 to 3 (read), 100 to 4 (write), 110 to 5 (burst stop), 010 to 6 (close row), 001 to 7 (refresh), 000 to 8 (mode load).
- R2: While `rstN` is low, `bankState` is 0 (idle) and `illegalCmd` is 0.
- R3: A command with `bankHit` low, or a code of 0 or 1, is never flagged. It causes no transition; only the running timers advance.
- R4: In idle (state 0), open row moves the bank to state 1 (activating). Refresh, mode load and close row are legal and leave the bank idle. Read, write and burst stop are flagged.
- R5: After an open row registered at edge k, `bankState` is 1 after edges k to k+T_RCD-2 and 2 (row active) after edge k+T_RCD-1.
- R6: In row active, a read or write moves the bank to 3 or 4. If `autoPre` is high, it moves to 5 or 6 instead. Close row moves it to 7 (precharging). Open row, refresh, mode load and burst stop are flagged.
- R7: A burst without auto close, registered at edge k, returns to row active after edge k+BL-1. BL is the value of `burstLen`, and 0 counts as 1. With BL=1 the bank stays in row active.
- R8: In state 3 or 4, read or write restarts a burst of the given kind. Close row truncates the burst and moves the bank to 7. Burst stop returns it to 2. Open row, refresh and mode load are flagged.
- R9: After a close row registered at edge k, the bank is 7 after edges k to k+T_RP-2 and idle after edge k+T_RP-1.
- R10: In states 1, 5, 6 and 7, any command with `bankHit` high and a code above 1 is flagged and leaves the state unchanged.
- R11: A burst with auto close registered at edge k holds state 5 or 6 until it reaches idle after edge k+BL+T_RP-1.
- R12: `illegalCmd` is registered. It is high for exactly the cycle after the edge that registered a flagged command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bankHit | input | 1 | Command addresses this bank |
| autoPre | input | 1 | Auto close bit of read/write |
| burstLen | input | BL_W | Programmed burst length in cycles |
| bankState | output | 3 | Current bank state code |
| illegalCmd | output | 1 | One-cycle flag for a disallowed command |
| cmdCode | output | 4 | Decoded command code |

## Verification
On every cycle, the assertions check three things. Commands sent during the protected phases and disallowed commands in idle are flagged. Unaddressed commands and no-ops are never flagged. The timed phases and bursts leave only to their allowed successor states, and a burst stop returns a running burst to row active. The exact cycle counts of tRCD, tRP, the burst length and the auto-close sum can only be shown by the bench's scenarios. The same holds for the length-one and length-zero burst cases, and for restart and truncation ordering within a burst.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [3:0] {
    CMD_INHIBIT = 4'd0,
    CMD_NOP     = 4'd1,
    CMD_ACTIVE  = 4'd2,
    CMD_READ    = 4'd3,
    CMD_WRITE   = 4'd4,
    CMD_BST     = 4'd5,
    CMD_PRE     = 4'd6,
    CMD_AREF    = 4'd7,
    CMD_LMR     = 4'd8
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE        = 3'd0,
    ST_ACTIVATING  = 3'd1,
    ST_ROW_ACTIVE  = 3'd2,
    ST_READ        = 3'd3,
    ST_WRITE       = 3'd4,
    ST_READ_AP     = 3'd5,
    ST_WRITE_AP    = 3'd6,
    ST_PRECHARGING = 3'd7
  } bank_state_e;

  typedef enum logic [1:0] {
    LD_RCD,
    LD_RP,
    LD_BURST,
    LD_BURST_RP
  } load_sel_e;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic      load;
    load_sel_e sel;
  } timer_ctl_t;

endpackage

// File: rtl/sdram_trk_decode.sv
module sdram_trk_decode
  import sdram_trk_pkg::*;
(
  input  logic csN,
  input  logic rasN,
  input  logic casN,
  input  logic weN,
  output cmd_e cmd
);

  always_comb begin
    if (csN) begin
      cmd = CMD_INHIBIT;
    end else begin
      unique case ({rasN, casN, weN})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACTIVE;
        3'b101:  cmd = CMD_READ;
        3'b100:  cmd = CMD_WRITE;
        3'b110:  cmd = CMD_BST;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_AREF;
        default: cmd = CMD_LMR;
      endcase
    end
  end

endmodule

// File: rtl/sdram_trk_timer.sv
module sdram_trk_timer
  import sdram_trk_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int BL_W  = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  timer_ctl_t       ctl,
  input  logic [BL_W-1:0]  burstLen,
  output logic             cntZero,
  output logic             burstSingle
);

  logic [BL_W:0]  burstEff;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  assign burstEff    = (burstLen == '0) ? (BL_W+1)'(1) : {1'b0, burstLen};
  assign burstSingle = (burstEff == (BL_W+1)'(1));
  assign cntZero     = (cnt == '0);

  always_comb begin
    unique case (ctl.sel)
      LD_RCD:   loadVal = CNT_W'(T_RCD - 2);
      LD_RP:    loadVal = CNT_W'(T_RP - 2);
      LD_BURST: loadVal = CNT_W'(burstEff) - CNT_W'(2);
      default:  loadVal = CNT_W'(burstEff) + CNT_W'(T_RP - 2);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.load) begin
      cnt <= loadVal;
    end else if (!cntZero) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/sdram_trk_ctrl.sv
module sdram_trk_ctrl
  import sdram_trk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  cmd_e        cmd,
  input  logic        bankHit,
  input  logic        autoPre,
  input  logic        cntZero,
  input  logic        burstSingle,
  output bank_state_e state,
  output logic        illegalCmd,
  output timer_ctl_t  tctl
);

  bank_state_e nxtState;
  logic        flagNow;
  logic        addressed;

  assign addressed = bankHit && (cmd != CMD_NOP) && (cmd != CMD_INHIBIT);

  always_comb begin
    nxtState = state;
    flagNow  = 1'b0;
    tctl     = '{load: 1'b0, sel: LD_RCD};

    // timer-driven progress, also taken when a command is flagged
    unique case (state)
      ST_ACTIVATING:            if (cntZero) nxtState = ST_ROW_ACTIVE;
      ST_READ, ST_WRITE:        if (cntZero) nxtState = ST_ROW_ACTIVE;
      ST_PRECHARGING:           if (cntZero) nxtState = ST_IDLE;
      ST_READ_AP, ST_WRITE_AP:  if (cntZero) nxtState = ST_IDLE;
      default:                  nxtState = state;
    endcase

    if (addressed) begin
      unique case (state)
        ST_IDLE: begin
          unique case (cmd)
            CMD_ACTIVE: begin
              nxtState = ST_ACTIVATING;
              tctl     = '{load: 1'b1, sel: LD_RCD};
            end
            CMD_AREF, CMD_LMR, CMD_PRE: nxtState = ST_IDLE;
            default: flagNow = 1'b1;
          endcase
        end
        ST_ROW_ACTIVE, ST_READ, ST_WRITE: begin
          unique case (cmd)
            CMD_READ, CMD_WRITE: begin
              if (autoPre) begin
                nxtState = (cmd == CMD_READ) ? ST_READ_AP : ST_WRITE_AP;
                tctl     = '{load: 1'b1, sel: LD_BURST_RP};
              end else if (burstSingle) begin
                nxtState = ST_ROW_ACTIVE;
              end else begin
                nxtState = (cmd == CMD_READ) ? ST_READ : ST_WRITE;
                tctl     = '{load: 1'b1, sel: LD_BURST};
              end
            end
            CMD_PRE: begin
              nxtState = ST_PRECHARGING;
              tctl     = '{load: 1'b1, sel: LD_RP};
            end
            CMD_BST: begin
              if (state == ST_ROW_ACTIVE) flagNow = 1'b1;
              else                        nxtState = ST_ROW_ACTIVE;
            end
            default: flagNow = 1'b1;
          endcase
        end
        default: flagNow = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      illegalCmd <= 1'b0;
    end else begin
      state      <= nxtState;
      illegalCmd <= flagNow;
    end
  end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_trk_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int BL_W  = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csN,
  input  logic            rasN,
  input  logic            casN,
  input  logic            weN,
  input  logic            bankHit,
  input  logic            autoPre,
  input  logic [BL_W-1:0] burstLen,
  output logic [2:0]      bankState,
  output logic            illegalCmd,
  output logic [3:0]      cmdCode
);

  localparam int CNT_W = $clog2((2**BL_W) + T_RP + T_RCD + 1);

  cmd_e        cmd;
  bank_state_e state;
  timer_ctl_t  tctl;
  logic        cntZero;
  logic        burstSingle;

  sdram_trk_decode u_decode (
    .csN (csN),
    .rasN(rasN),
    .casN(casN),
    .weN (weN),
    .cmd (cmd)
  );

  sdram_trk_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .bankHit    (bankHit),
    .autoPre    (autoPre),
    .cntZero    (cntZero),
    .burstSingle(burstSingle),
    .state      (state),
    .illegalCmd (illegalCmd),
    .tctl       (tctl)
  );

  sdram_trk_timer #(
    .T_RCD(T_RCD),
    .T_RP (T_RP),
    .BL_W (BL_W),
    .CNT_W(CNT_W)
  ) u_timer (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (tctl),
    .burstLen   (burstLen),
    .cntZero    (cntZero),
    .burstSingle(burstSingle)
  );

  assign bankState = state;
  assign cmdCode   = cmd;

endmodule

// File: rtl/sdram_bank_tracker_chk.sv
module sdram_bank_tracker_chk (
  input logic       clk,
  input logic       rstN,
  input logic       bankHit,
  input logic [2:0] bankState,
  input logic       illegalCmd,
  input logic [3:0] cmdCode
);

  AST_IDLE_READ_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (bankState == 3'd0 && bankHit && cmdCode == 4'd3) |=> illegalCmd); // R4

  AST_PROTECTED_NO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    ((bankState == 3'd1 || bankState == 3'd5 || bankState == 3'd6 || bankState == 3'd7)
      && bankHit && cmdCode > 4'd1) |=> (illegalCmd && bankState == $past(bankState)
      || illegalCmd && (bankState == 3'd2 || bankState == 3'd0))); // R10

  AST_UNADDRESSED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!bankHit || cmdCode <= 4'd1) |=> !illegalCmd); // R3

  AST_ACTIVATING_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (bankState == 3'd1) |=> (bankState == 3'd1 || bankState == 3'd2)); // R5

  AST_PRECHARGE_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (bankState == 3'd7) |=> (bankState == 3'd7 || bankState == 3'd0)); // R9

  AST_AUTOCLOSE_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (bankState == 3'd5 || bankState == 3'd6) |=> (bankState == $past(bankState) || bankState == 3'd0)); // R11

  AST_BST_ENDS_BURST: assert property (@(posedge clk) disable iff (!rstN)
    ((bankState == 3'd3 || bankState == 3'd4) && bankHit && cmdCode == 4'd5)
      |=> (bankState == 3'd2 && !illegalCmd)); // R8

endmodule

bind sdram_bank_tracker sdram_bank_tracker_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .bankHit   (bankHit),
  .bankState (bankState),
  .illegalCmd(illegalCmd),
  .cmdCode   (cmdCode)
);

// File: tb/sdram_bank_tracker_tb.sv
module sdram_bank_tracker_tb;
  import sdram_trk_pkg::*;

  localparam int BL_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic bankHit = 1'b1, autoPre = 1'b0;
  logic [BL_W-1:0] burstLen = 4'd4;
  logic [2:0] bankState;
  logic illegalCmd;
  logic [3:0] cmdCode;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [2:0] st;
    logic       ill;
    string      req;
  } exp_t;
  exp_t expQ[$];

  always #5 clk = ~clk;

  sdram_bank_tracker #(.T_RCD(3), .T_RP(3), .BL_W(BL_W)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankHit(bankHit), .autoPre(autoPre), .burstLen(burstLen),
    .bankState(bankState), .illegalCmd(illegalCmd), .cmdCode(cmdCode)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input cmd_e c);
    case (c)
      CMD_INHIBIT: {csN, rasN, casN, weN} = 4'b1111;
      CMD_NOP:     {csN, rasN, casN, weN} = 4'b0111;
      CMD_ACTIVE:  {csN, rasN, casN, weN} = 4'b0011;
      CMD_READ:    {csN, rasN, casN, weN} = 4'b0101;
      CMD_WRITE:   {csN, rasN, casN, weN} = 4'b0100;
      CMD_BST:     {csN, rasN, casN, weN} = 4'b0110;
      CMD_PRE:     {csN, rasN, casN, weN} = 4'b0010;
      CMD_AREF:    {csN, rasN, casN, weN} = 4'b0001;
      default:     {csN, rasN, casN, weN} = 4'b0000;
    endcase
  endtask

  // driver: one command per cycle, expected outcome pushed to the scoreboard
  task automatic step(input cmd_e c, input logic hit, input logic ap,
                      input logic [2:0] es, input logic ei, input string req);
    exp_t e;
    @(negedge clk);
    drive(c);
    bankHit = hit;
    autoPre = ap;
    #1;
    check(cmdCode == 4'(c), "R1", "cmdCode", cmdCode, c);
    e.st = es; e.ill = ei; e.req = req;
    expQ.push_back(e);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check(bankState == e.st, e.req, "bankState", bankState, e.st);
        check(illegalCmd == e.ill, e.req, "illegalCmd", illegalCmd, e.ill);
      end
    end
  end

  initial begin
    #2_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bankState == 3'd0, "R2", "reset bankState", bankState, 0);
    check(illegalCmd == 1'b0, "R2", "reset illegalCmd", illegalCmd, 0);
    rstN = 1'b1;

    // idle behaviour
    step(CMD_READ,   1, 0, 3'd0, 1, "R4");
    step(CMD_NOP,    1, 0, 3'd0, 0, "R12");
    step(CMD_AREF,   1, 0, 3'd0, 0, "R4");
    step(CMD_LMR,    1, 0, 3'd0, 0, "R4");
    step(CMD_PRE,    1, 0, 3'd0, 0, "R4");
    step(CMD_BST,    1, 0, 3'd0, 1, "R4");
    step(CMD_ACTIVE, 0, 0, 3'd0, 0, "R3");
    step(CMD_ACTIVE, 1, 0, 3'd1, 0, "R4");
    step(CMD_READ,   1, 0, 3'd1, 1, "R10");
    step(CMD_NOP,    1, 0, 3'd2, 0, "R5");
    // row active
    step(CMD_BST,    1, 0, 3'd2, 1, "R6");
    step(CMD_AREF,   1, 0, 3'd2, 1, "R6");
    step(CMD_READ,   1, 0, 3'd3, 0, "R6");
    step(CMD_NOP,    1, 0, 3'd3, 0, "R7");
    step(CMD_WRITE,  0, 0, 3'd3, 0, "R3");
    step(CMD_NOP,    1, 0, 3'd2, 0, "R7");
    // burst commands
    step(CMD_WRITE,  1, 0, 3'd4, 0, "R6");
    step(CMD_READ,   1, 0, 3'd3, 0, "R8");
    step(CMD_WRITE,  1, 0, 3'd4, 0, "R8");
    step(CMD_BST,    1, 0, 3'd2, 0, "R8");
    step(CMD_WRITE,  1, 0, 3'd4, 0, "R8");
    step(CMD_ACTIVE, 1, 0, 3'd4, 1, "R8");
    step(CMD_PRE,    1, 0, 3'd7, 0, "R8");
    step(CMD_ACTIVE, 1, 0, 3'd7, 1, "R10");
    step(CMD_NOP,    1, 0, 3'd0, 0, "R9");
    // read with auto close
    step(CMD_ACTIVE, 1, 0, 3'd1, 0, "R5");
    step(CMD_NOP,    1, 0, 3'd1, 0, "R5");
    step(CMD_NOP,    1, 0, 3'd2, 0, "R5");
    step(CMD_READ,   1, 1, 3'd5, 0, "R6");
    step(CMD_PRE,    1, 0, 3'd5, 1, "R10");
    step(CMD_INHIBIT,1, 0, 3'd5, 0, "R3");
    step(CMD_NOP,    1, 0, 3'd5, 0, "R11");
    step(CMD_WRITE,  1, 0, 3'd5, 1, "R10");
    step(CMD_NOP,    1, 0, 3'd5, 0, "R11");
    step(CMD_NOP,    1, 0, 3'd0, 0, "R11");
    // write with auto close
    step(CMD_ACTIVE, 1, 0, 3'd1, 0, "R5");
    step(CMD_NOP,    1, 0, 3'd1, 0, "R5");
    step(CMD_NOP,    1, 0, 3'd2, 0, "R5");
    step(CMD_WRITE,  1, 1, 3'd6, 0, "R6");
    for (int i = 0; i < 5; i++) step(CMD_NOP, 1, 0, 3'd6, 0, "R11");
    step(CMD_NOP,    1, 0, 3'd0, 0, "R11");
    // single-beat bursts
    burstLen = 4'd1;
    step(CMD_ACTIVE, 1, 0, 3'd1, 0, "R5");
    step(CMD_NOP,    1, 0, 3'd1, 0, "R5");
    step(CMD_NOP,    1, 0, 3'd2, 0, "R5");
    step(CMD_READ,   1, 0, 3'd2, 0, "R7");
    burstLen = 4'd0;
    step(CMD_WRITE,  1, 0, 3'd2, 0, "R7");
    step(CMD_PRE,    1, 0, 3'd7, 0, "R6");
    step(CMD_NOP,    1, 0, 3'd7, 0, "R9");
    step(CMD_NOP,    1, 0, 3'd0, 0, "R9");
    step(CMD_NOP,    1, 0, 3'd0, 0, "R12");

    @(negedge clk);
    drive(CMD_NOP);
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule